// File: doc/BRIEF.md
# Ring Oscillator Response Generator

This block is the digital measurement core of a response generator built on ring oscillators. A set of free-running oscillators sits outside the block. Their outputs arrive as asynchronous, clock-like signals, and the block enables only the oscillators it is measuring. For each step of a run, a challenge picks two oscillators through a pair of multiplexers. The block counts the rising edges of each one over the same gate window, which is timed in system-clock cycles. It then compares the two counts and produces one response bit. That bit is 1 when the first oscillator is faster.

A run starts with a pulse on `start`. The block captures the challenge, the keep mask, the bit count and the window length at that moment. It then walks through up to `RESP_W` challenge steps. A keep-mask bit of 0 drops a step that is known to be unstable. A dropped step costs one cycle and adds no bit. Kept bits are shifted into a response word and a matching tie-flag word. A one-cycle `done` pulse ends the run.

Top module: `ro_puf_core`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `done` is 0 and `response`, `tieFlags`, `bitCount` and `roEnable` are all 0.
- R2: At step k (counting from 0), the block compares oscillator (chalA + k) mod NUM_OSC against oscillator (chalB + k) mod NUM_OSC. During that measurement `roEnable` has exactly the bits of those two oscillators set, or one bit if they are the same. `roEnable` is 0 outside measurements.
- R3: A measured bit is 1 when the rising-edge count of the first selected oscillator is strictly greater than the count of the second, and 0 otherwise.
- R4: When the two counts are equal, the bit is 0 and the tie flag at the same position of `tieFlags` is 1. Otherwise that tie flag is 0.
- R5: Keep-mask bit k (bit 0 belongs to step 0) set to 0 skips step k. That step gets no measurement, no enable and no response bit.
- R6: Each new bit enters `response` and `tieFlags` at bit 0, and the bits collected earlier move up one place. So the first collected bit ends at position bitCount-1. Positions at and above `bitCount` are 0. Both words clear at `start`.
- R7: A run ends once `bitCount` equals the captured `numBits` or all RESP_W steps have been visited. `done` is then high for exactly one cycle. A `numBits` of 0 ends the run with no measurement.
- R8: Each measured step enables its oscillators for exactly max(winLen, 1) system-clock cycles.
- R9: A `start` pulse during a run is ignored. It causes no second `done` and no further measurement.
- R10: Changes on `chalA`, `chalB`, `keepMask`, `numBits` or `winLen` during a run do not affect that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| roIn | input | NUM_OSC | Asynchronous oscillator outputs |
| roEnable | output | NUM_OSC | Per-oscillator run enable |
| start | input | 1 | Starts a run when idle |
| chalA | input | SEL_W | Base index of the first oscillator |
| chalB | input | SEL_W | Base index of the second oscillator |
| keepMask | input | RESP_W | Keep bit per challenge step |
| numBits | input | NB_W | Number of response bits wanted |
| winLen | input | WIN_W | Gate window in system-clock cycles |
| response | output | RESP_W | Collected response bits |
| tieFlags | output | RESP_W | Tie flag per collected bit |
| bitCount | output | NB_W | Bits collected in the last run |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A wrong step index or a wrong multiplexer selection shows on `roEnable` in the first cycle of the affected window. This happens long before any response bit is formed, so the bench checks the enabled pair at every window start. A counter that leaks edges or fails to clear appears as a wrong bit or a wrong tie flag at the end of that run. A miscounted window length shows in the number of enabled cycles for each run. A control error that skips, repeats or overruns a step shows at `done` as a wrong `bitCount` or shifted response positions.

// File: rtl/ro_puf_pkg.sv
package ro_puf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_MEAS,
    ST_CMP,
    ST_DONE
  } puf_state_t;

  typedef struct packed {
    logic loadCfg;
    logic clrCnt;
    logic countEn;
    logic oscOn;
    logic shiftBit;
  } puf_strobe_t;

endpackage

// File: rtl/ro_puf_ctrl.sv
module ro_puf_ctrl
  import ro_puf_pkg::*;
#(
  parameter int RESP_W = 8,
  parameter int WIN_W  = 16,
  parameter int NB_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              stepKeep,
  input  logic [NB_W-1:0]   cfgBits,
  input  logic [WIN_W-1:0]  cfgWin,
  output puf_strobe_t       strb,
  output logic [NB_W-1:0]   stepIdx,
  output logic [NB_W-1:0]   bitCount,
  output logic              done
);

  localparam logic [NB_W-1:0] LAST_STEP = NB_W'(RESP_W);

  puf_state_t       state;
  logic [WIN_W-1:0] winCnt;
  logic             runOver;

  assign runOver = (bitCount >= cfgBits) || (stepIdx == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepIdx  <= '0;
      bitCount <= '0;
      winCnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            stepIdx  <= '0;
            bitCount <= '0;
            state    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (runOver) begin
            state <= ST_DONE;
          end else if (stepKeep) begin
            winCnt <= cfgWin;
            state  <= ST_MEAS;
          end else begin
            stepIdx <= stepIdx + 1'b1;
          end
        end
        ST_MEAS: begin
          if (winCnt <= WIN_W'(1)) state <= ST_CMP;
          else winCnt <= winCnt - 1'b1;
        end
        ST_CMP: begin
          stepIdx  <= stepIdx + 1'b1;
          bitCount <= bitCount + 1'b1;
          state    <= ST_SCAN;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadCfg  = (state == ST_IDLE) && start;
    strb.clrCnt   = (state == ST_SCAN);
    strb.countEn  = (state == ST_MEAS);
    strb.oscOn    = (state == ST_MEAS);
    strb.shiftBit = (state == ST_CMP);
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/ro_puf_dp.sv
module ro_puf_dp
  import ro_puf_pkg::*;
#(
  parameter int NUM_OSC = 8,
  parameter int SEL_W   = 3,
  parameter int RESP_W  = 8,
  parameter int CNT_W   = 16,
  parameter int WIN_W   = 16,
  parameter int NB_W    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OSC-1:0] roIn,
  input  puf_strobe_t        strb,
  input  logic [NB_W-1:0]    stepIdx,
  input  logic [SEL_W-1:0]   chalA,
  input  logic [SEL_W-1:0]   chalB,
  input  logic [RESP_W-1:0]  keepMask,
  input  logic [NB_W-1:0]    numBits,
  input  logic [WIN_W-1:0]   winLen,
  output logic [NUM_OSC-1:0] roEnable,
  output logic [NB_W-1:0]    cfgBits,
  output logic [WIN_W-1:0]   cfgWin,
  output logic               stepKeep,
  output logic [RESP_W-1:0]  response,
  output logic [RESP_W-1:0]  tieFlags
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SEL_W-1:0]   cfgA, cfgB, selA, selB;
  logic [RESP_W-1:0]  cfgKeep;
  logic [NUM_OSC-1:0] rise;
  logic [CNT_W-1:0]   cntA, cntB;
  logic               aFaster, sameCnt;

  // every oscillator keeps its own synchroniser so that switching the
  // selection never feeds a half-settled value into a counter
  for (genvar g = 0; g < NUM_OSC; g++) begin : g_sync
    logic [2:0] syncQ;
    always_ff @(posedge clk) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[1:0], roIn[g]};
    end
    assign rise[g] = syncQ[1] & ~syncQ[2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgA    <= '0;
      cfgB    <= '0;
      cfgKeep <= '0;
      cfgBits <= '0;
      cfgWin  <= '0;
    end else if (strb.loadCfg) begin
      cfgA    <= chalA;
      cfgB    <= chalB;
      cfgKeep <= keepMask;
      cfgBits <= numBits;
      cfgWin  <= winLen;
    end
  end

  assign selA     = cfgA + SEL_W'(stepIdx);
  assign selB     = cfgB + SEL_W'(stepIdx);
  assign stepKeep = (stepIdx < NB_W'(RESP_W)) ? cfgKeep[stepIdx] : 1'b0;
  assign roEnable = strb.oscOn ? ((NUM_OSC'(1) << selA) | (NUM_OSC'(1) << selB))
                               : '0;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clrCnt) begin
      cntA <= '0;
      cntB <= '0;
    end else if (strb.countEn) begin
      if (rise[selA] && cntA != CNT_MAX) cntA <= cntA + 1'b1;
      if (rise[selB] && cntB != CNT_MAX) cntB <= cntB + 1'b1;
    end
  end

  assign aFaster = cntA > cntB;
  assign sameCnt = cntA == cntB;

  always_ff @(posedge clk) begin
    if (!rstN || strb.loadCfg) begin
      response <= '0;
      tieFlags <= '0;
    end else if (strb.shiftBit) begin
      response <= {response[RESP_W-2:0], aFaster};
      tieFlags <= {tieFlags[RESP_W-2:0], sameCnt};
    end
  end

endmodule

// File: rtl/ro_puf_core.sv
module ro_puf_core
  import ro_puf_pkg::*;
#(
  parameter int NUM_OSC = 8,
  parameter int RESP_W  = 8,
  parameter int CNT_W   = 16,
  parameter int WIN_W   = 16,
  parameter int SEL_W   = $clog2(NUM_OSC),
  parameter int NB_W    = $clog2(RESP_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OSC-1:0] roIn,
  output logic [NUM_OSC-1:0] roEnable,
  input  logic               start,
  input  logic [SEL_W-1:0]   chalA,
  input  logic [SEL_W-1:0]   chalB,
  input  logic [RESP_W-1:0]  keepMask,
  input  logic [NB_W-1:0]    numBits,
  input  logic [WIN_W-1:0]   winLen,
  output logic [RESP_W-1:0]  response,
  output logic [RESP_W-1:0]  tieFlags,
  output logic [NB_W-1:0]    bitCount,
  output logic               done
);

  puf_strobe_t      strb;
  logic [NB_W-1:0]  stepIdx;
  logic [NB_W-1:0]  cfgBits;
  logic [WIN_W-1:0] cfgWin;
  logic             stepKeep;

  ro_puf_ctrl #(
    .RESP_W(RESP_W), .WIN_W(WIN_W), .NB_W(NB_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stepKeep(stepKeep),
    .cfgBits(cfgBits), .cfgWin(cfgWin), .strb(strb),
    .stepIdx(stepIdx), .bitCount(bitCount), .done(done)
  );

  ro_puf_dp #(
    .NUM_OSC(NUM_OSC), .SEL_W(SEL_W), .RESP_W(RESP_W),
    .CNT_W(CNT_W), .WIN_W(WIN_W), .NB_W(NB_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .roIn(roIn), .strb(strb), .stepIdx(stepIdx),
    .chalA(chalA), .chalB(chalB), .keepMask(keepMask), .numBits(numBits),
    .winLen(winLen), .roEnable(roEnable), .cfgBits(cfgBits),
    .cfgWin(cfgWin), .stepKeep(stepKeep), .response(response),
    .tieFlags(tieFlags)
  );

endmodule

// File: rtl/ro_puf_core_chk.sv
module ro_puf_core_chk #(
  parameter int NUM_OSC = 8,
  parameter int RESP_W  = 8,
  parameter int NB_W    = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_OSC-1:0] roEnable,
  input logic [RESP_W-1:0]  response,
  input logic [RESP_W-1:0]  tieFlags,
  input logic [NB_W-1:0]    bitCount,
  input logic               done
);

  AST_ENABLE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    $countones(roEnable) <= 2);  // R2

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (roEnable != '0 && $past(roEnable) != '0) |-> roEnable == $past(roEnable));  // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> roEnable == '0);  // R8

  AST_TIE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (tieFlags & response) == '0);  // R4

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= NB_W'(RESP_W));  // R7

endmodule

bind ro_puf_core ro_puf_core_chk #(
  .NUM_OSC(NUM_OSC), .RESP_W(RESP_W), .NB_W(NB_W)
) u_chk (
  .clk(clk), .rstN(rstN), .roEnable(roEnable), .response(response),
  .tieFlags(tieFlags), .bitCount(bitCount), .done(done)
);

// File: tb/sim_ro_puf_core.sv
`timescale 1ns/1ps
module sim_ro_puf_core;

  typedef struct packed {
    logic [2:0]  a;
    logic [2:0]  b;
    logic [7:0]  keep;
    logic [3:0]  nb;
    logic [15:0] win;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 3'd1, 8'hFF, 4'd8, 16'd100},
    '{3'd3, 3'd0, 8'hA5, 4'd4, 16'd80},
    '{3'd5, 3'd0, 8'h01, 4'd8, 16'd100},
    '{3'd2, 3'd6, 8'hFF, 4'd3, 16'd64},
    '{3'd4, 3'd4, 8'h0F, 4'd8, 16'd50},
    '{3'd7, 3'd1, 8'h00, 4'd5, 16'd40},
    '{3'd1, 3'd2, 8'hFF, 4'd0, 16'd40}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] roIn = '0;
  logic [7:0] roEnable;
  logic       start = 1'b0;
  logic [2:0] chalA = '0, chalB = '0;
  logic [7:0] keepMask = '0;
  logic [3:0] numBits = '0;
  logic [15:0] winLen = '0;
  logic [7:0] response, tieFlags;
  logic [3:0] bitCount;
  logic       done;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [7:0] expPair [8];
  logic [7:0] expResp, expTie;
  logic [3:0] expCnt;

  ro_puf_core u0 (
    .clk(clk), .rstN(rstN), .roIn(roIn), .roEnable(roEnable), .start(start),
    .chalA(chalA), .chalB(chalB), .keepMask(keepMask), .numBits(numBits),
    .winLen(winLen), .response(response), .tieFlags(tieFlags),
    .bitCount(bitCount), .done(done)
  );

  always #4 clk = ~clk;

  function automatic int halfOf(input int i);
    case (i)
      0: return 10;  1: return 13;  2: return 17;  3: return 22;
      4: return 28;  5: return 10;  6: return 35;  default: return 45;
    endcase
  endfunction

  // behavioural oscillators: idle low, restart in phase when enabled
  initial begin
    real  tStart [8];
    logic [7:0] prevEn = '0;
    for (int i = 0; i < 8; i++) tStart[i] = 0.0;
    #0.5;
    forever begin
      for (int i = 0; i < 8; i++) begin
        if (roEnable[i] && !prevEn[i]) tStart[i] = $realtime;
        roIn[i] = roEnable[i] &&
                  ((int'($floor(($realtime - tStart[i]) / halfOf(i))) % 2) == 1);
        prevEn[i] = roEnable[i];
      end
      #1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic model(input vec_t v);
    logic [2:0] sa, sb;
    expResp = '0;
    expTie  = '0;
    expCnt  = '0;
    for (int k = 0; k < 8; k++) begin
      if (expCnt < v.nb && v.keep[k]) begin
        sa = v.a + 3'(k);
        sb = v.b + 3'(k);
        expPair[expCnt] = (8'd1 << sa) | (8'd1 << sb);
        expResp = {expResp[6:0], halfOf(int'(sa)) < halfOf(int'(sb))};
        expTie  = {expTie[6:0],  halfOf(int'(sa)) == halfOf(int'(sb))};
        expCnt  = expCnt + 1'b1;
      end
    end
  endtask

  task automatic runVec(input vec_t v, input bit disturb);
    int  enCyc = 0;
    int  seen = 0;
    int  extra = 0;
    bit  gotDone = 0;
    logic [7:0] prevE = '0;
    model(v);
    @(negedge clk);
    chalA = v.a; chalB = v.b; keepMask = v.keep; numBits = v.nb; winLen = v.win;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 20000 && !gotDone; c++) begin
      @(negedge clk);
      if (roEnable != '0) begin
        enCyc++;
        if (prevE == '0) begin
          if (seen < 8)  // R2 pair of oscillators for this step
            check(roEnable == expPair[seen], "R2 enabled pair", 32'(roEnable), 32'(expPair[seen]));
          seen++;
        end
      end
      prevE = roEnable;
      if (done) gotDone = 1;
      if (disturb && c == 150) begin
        chalA = ~v.a; chalB = v.a; keepMask = ~v.keep; numBits = 4'd2; winLen = 16'd7;
        start = 1'b1;
      end
      if (disturb && c == 151) start = 1'b0;
    end
    check(gotDone, "R7 run completes", 32'(gotDone), 32'd1);
    check(response == expResp, "R3 R6 response word", 32'(response), 32'(expResp));
    check(tieFlags == expTie, "R4 tie flags", 32'(tieFlags), 32'(expTie));
    check(bitCount == expCnt, "R5 R7 bit count", 32'(bitCount), 32'(expCnt));
    check(seen == int'(expCnt), "R5 measured steps", 32'(seen), 32'(expCnt));
    check(enCyc == int'(expCnt) * int'(v.win), "R8 window cycles", 32'(enCyc),
          32'(int'(expCnt) * int'(v.win)));
    @(negedge clk);
    check(done == 1'b0, "R7 done width", 32'(done), 32'd0);
    if (disturb) begin
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        if (done || roEnable != '0) extra++;
      end
      check(extra == 0, "R9 start ignored while busy", 32'(extra), 32'd0);
      check(response == expResp, "R10 config held", 32'(response), 32'(expResp));
    end
  endtask

  initial begin
    #(8 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL R7 watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({done, response, tieFlags, bitCount, roEnable} == '0, "R1 in reset",
          32'({done, response, tieFlags, bitCount}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({done, response, tieFlags, bitCount, roEnable} == '0, "R1 after reset",
          32'({done, response, tieFlags, bitCount}), 32'd0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i], 1'b0);

    runVec(VECS[0], 1'b1);  // R9 R10

    // reset in the middle of a run clears everything (R1)
    @(negedge clk);
    chalA = 3'd0; chalB = 3'd1; keepMask = 8'hFF; numBits = 4'd8; winLen = 16'd100;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (250) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check({done, response, tieFlags, bitCount, roEnable} == '0, "R1 mid-run reset",
          32'({response, tieFlags, bitCount}), 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(roEnable == '0 && done == 1'b0, "R1 idle after reset", 32'(roEnable), 32'd0);

    summary();
  end

endmodule